// File: doc/BRIEF.md
# Transmit Descriptor Ring Poller

This block keeps a read position for each of 255 transmit DMA channels. Each channel owns a circular ring of 256 descriptors in host memory. Every descriptor is sixteen bytes long, so one ring fills a 4 KB region. An external bandwidth scheduler picks which channel to visit and how often. It presents the channel number with a request strobe. The poller then forms the host address of that channel's current descriptor and reads the descriptor's first word. Bit 31 of that word shows whether the descriptor is queued.

A queued descriptor is handed to the segmentation stage as a one-cycle strobe that carries the channel and the descriptor address. The channel's position then moves forward by one and wraps from 255 to 0. An unqueued descriptor does not move the position. It raises a one-cycle idle-cell strobe for that channel instead. The next visit to the channel therefore reads the same descriptor again, and no entry is ever skipped.

The controller has four states. `ST_IDLE` accepts a request. `ST_FETCH` holds the host read until the response arrives. `ST_ISSUE` emits the segmentation strobe, and `ST_STALL` emits the idle strobe. Both of the last two return to `ST_IDLE`. The transitions are:
- IDLE→FETCH on a request for any channel other than 0.
- FETCH→ISSUE on a response with the flag set.
- FETCH→STALL on a response with the flag clear.
- ISSUE→IDLE and STALL→IDLE unconditionally.

Ring base addresses are loaded through a write port indexed by channel number.

Top module: `txring_poller`

## Requirements
- R1: A synchronous reset clears every channel's position to 0, raises `svc_ready`, and leaves `rd_req`, `seg_valid` and `idle_valid` low.
- R2: The descriptor address is the channel base plus position × 16. The base is stored with bits 1:0 forced to zero, so a base written as 0x10000003 gives 0x10000000 for position 0.
- R3: Only one host read is outstanding at a time. `rd_req` stays high with a stable `rd_addr` until `rd_rsp_valid`. A request presented while `svc_ready` is low is ignored.
- R4: A response with bit 31 = 1 raises `seg_valid` for exactly one cycle, on the cycle after the response. `seg_chan` and `seg_addr` give the channel and the descriptor address, and that channel's position increases by 1.
- R5: A response with bit 31 = 0 raises `idle_valid` for exactly one cycle, on the cycle after the response, with `idle_chan` set to the channel. The position is unchanged, so the next visit reads the same address.
- R6: After 256 queued descriptors have been issued on one channel, its position wraps from 255 back to 0.
- R7: Each channel's position is independent. Servicing one channel never changes another channel's position.
- R8: A request for channel 0 is ignored. No read is issued and `svc_ready` stays high.
- R9: A base-address write to a channel also clears that channel's position to 0. If it lands in the same cycle as an advance on that channel, the write wins.
- R10: `seg_valid` and `idle_valid` are never high together, and each host read ends in exactly one of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| svc_valid | input | 1 | Scheduler request strobe |
| svc_chan | input | 8 | Channel to service |
| svc_ready | output | 1 | Poller can accept a request |
| cfg_we | input | 1 | Base-address write enable |
| cfg_chan | input | 8 | Channel whose base is written |
| cfg_base | input | 32 | Ring base byte address |
| rd_req | output | 1 | Host read request, held until response |
| rd_addr | output | 32 | Byte address of descriptor first word |
| rd_rsp_valid | input | 1 | Host read data valid |
| rd_rsp_data | input | 32 | First descriptor word; bit 31 = queued |
| seg_valid | output | 1 | Descriptor handed to segmentation |
| seg_chan | output | 8 | Channel of the issued descriptor |
| seg_addr | output | 32 | Address of the issued descriptor |
| idle_valid | output | 1 | Idle-cell request |
| idle_chan | output | 8 | Channel needing an idle cell |

## Verification
The assertions check several rules on every cycle:
- a held read keeps its address until answered;
- the outcome strobe matches the flag of the response;
- the two strobes are exclusive and last one cycle;
- a channel-0 request leaves the poller ready;
- a channel's position steps by one on an issue and clears on a base write.

Some behaviours only the bench scenarios can show, because they span many visits:
- that a stalled channel resumes at the very descriptor it refused;
- that the wrap after 256 issues returns to the base;
- that a request made while busy leaves no trace;
- that channels never disturb one another.

// File: rtl/txp_pkg.sv
package txp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_ISSUE = 2'd2,
        ST_STALL = 2'd3
    } poll_state_t;
endpackage

// File: rtl/txp_ring_state.sv
module txp_ring_state #(
    parameter int CH_W   = 8,
    parameter int IDX_W  = 8,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_chan,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic              adv_en,
    input  logic [CH_W-1:0]   adv_chan,
    input  logic [CH_W-1:0]   look_chan,
    output logic [ADDR_W-1:0] look_base,
    output logic [IDX_W-1:0]  look_idx
);
    localparam int NUM_CH = 1 << CH_W;

    logic [IDX_W-1:0]  idx_q  [NUM_CH];
    logic [ADDR_W-1:0] base_q [NUM_CH];

    // Positions: reset to zero, cleared by a base write, stepped by an issue.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int c = 0; c < NUM_CH; c++) begin
                idx_q[c] <= '0;
            end
        end else begin
            if (adv_en) begin
                idx_q[adv_chan] <= idx_q[adv_chan] + IDX_W'(1);
            end
            if (cfg_we) begin
                idx_q[cfg_chan] <= '0;
            end
        end
    end

    // Bases are configuration data and carry no reset.
    always_ff @(posedge clk) begin
        if (cfg_we) begin
            base_q[cfg_chan] <= {cfg_base[ADDR_W-1:2], 2'b00};
        end
    end

    assign look_base = base_q[look_chan];
    assign look_idx  = idx_q[look_chan];

    // R4
    idx_step_chk: assert property (@(posedge clk) disable iff (rst)
        (adv_en && !(cfg_we && cfg_chan == adv_chan))
        |=> idx_q[$past(adv_chan)] == $past(idx_q[adv_chan]) + IDX_W'(1));

    // R9
    idx_clear_chk: assert property (@(posedge clk) disable iff (rst)
        cfg_we |=> idx_q[$past(cfg_chan)] == '0);
endmodule

// File: rtl/txp_addr_gen.sv
module txp_addr_gen #(
    parameter int IDX_W       = 8,
    parameter int ADDR_W      = 32,
    parameter int ENTRY_SHIFT = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [IDX_W-1:0]  idx,
    output logic [ADDR_W-1:0] entry_addr
);
    localparam int OFS_W = IDX_W + ENTRY_SHIFT;

    logic [OFS_W-1:0] offset;

    assign offset     = {idx, {ENTRY_SHIFT{1'b0}}};
    assign entry_addr = base + ADDR_W'(offset);
endmodule

// File: rtl/txp_fsm.sv
module txp_fsm
    import txp_pkg::*;
#(
    parameter int CH_W   = 8,
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              svc_valid,
    input  logic [CH_W-1:0]   svc_chan,
    input  logic [ADDR_W-1:0] svc_addr,
    output logic              svc_ready,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_rsp_valid,
    input  logic              rsp_flag,
    output logic              seg_valid,
    output logic              idle_valid,
    output logic [CH_W-1:0]   cur_chan,
    output logic              adv_en
);
    poll_state_t state_q, state_d;
    logic [CH_W-1:0]   chan_q;
    logic [ADDR_W-1:0] addr_q;
    logic              accept;

    assign accept = (state_q == ST_IDLE) && svc_valid && (svc_chan != '0);

    // State register and request capture
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            chan_q  <= '0;
            addr_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                chan_q <= svc_chan;
                addr_q <= svc_addr;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_FETCH;
            ST_FETCH: if (rd_rsp_valid) state_d = rsp_flag ? ST_ISSUE : ST_STALL;
            ST_ISSUE: state_d = ST_IDLE;
            ST_STALL: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        svc_ready  = 1'b0;
        rd_req     = 1'b0;
        seg_valid  = 1'b0;
        idle_valid = 1'b0;
        adv_en     = 1'b0;
        unique case (state_q)
            ST_IDLE:  svc_ready = 1'b1;
            ST_FETCH: rd_req = 1'b1;
            ST_ISSUE: begin
                seg_valid = 1'b1;
                adv_en    = 1'b1;
            end
            ST_STALL: idle_valid = 1'b1;
        endcase
    end

    assign rd_addr  = addr_q;
    assign cur_chan = chan_q;

    // R3
    read_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_rsp_valid) |=> (rd_req && $stable(rd_addr)));

    // R4
    queued_issue_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_rsp_valid && rsp_flag) |=> (seg_valid && !rd_req));

    // R5
    unqueued_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_rsp_valid && !rsp_flag) |=> (idle_valid && !rd_req));

    // R10
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({seg_valid, idle_valid}));

    // R10
    strobe_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        (seg_valid || idle_valid) |=> !(seg_valid || idle_valid));

    // R8
    chan_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (svc_ready && svc_valid && svc_chan == '0) |=> (svc_ready && !rd_req));
endmodule

// File: rtl/txring_poller.sv
module txring_poller #(
    parameter int CH_W        = 8,
    parameter int IDX_W       = 8,
    parameter int ADDR_W      = 32,
    parameter int ENTRY_SHIFT = 4,
    parameter int FLAG_BIT    = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              svc_valid,
    input  logic [CH_W-1:0]   svc_chan,
    output logic              svc_ready,
    input  logic              cfg_we,
    input  logic [CH_W-1:0]   cfg_chan,
    input  logic [ADDR_W-1:0] cfg_base,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_rsp_valid,
    input  logic [31:0]       rd_rsp_data,
    output logic              seg_valid,
    output logic [CH_W-1:0]   seg_chan,
    output logic [ADDR_W-1:0] seg_addr,
    output logic              idle_valid,
    output logic [CH_W-1:0]   idle_chan
);
    logic [ADDR_W-1:0] look_base;
    logic [IDX_W-1:0]  look_idx;
    logic [ADDR_W-1:0] entry_addr;
    logic [CH_W-1:0]   cur_chan;
    logic              adv_en;

    txp_ring_state #(
        .CH_W(CH_W), .IDX_W(IDX_W), .ADDR_W(ADDR_W)
    ) u_state (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_base(cfg_base),
        .adv_en(adv_en), .adv_chan(cur_chan),
        .look_chan(svc_chan), .look_base(look_base), .look_idx(look_idx)
    );

    txp_addr_gen #(
        .IDX_W(IDX_W), .ADDR_W(ADDR_W), .ENTRY_SHIFT(ENTRY_SHIFT)
    ) u_addr (
        .base(look_base), .idx(look_idx), .entry_addr(entry_addr)
    );

    txp_fsm #(
        .CH_W(CH_W), .ADDR_W(ADDR_W)
    ) u_fsm (
        .clk(clk), .rst(rst),
        .svc_valid(svc_valid), .svc_chan(svc_chan), .svc_addr(entry_addr),
        .svc_ready(svc_ready),
        .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_rsp_valid(rd_rsp_valid), .rsp_flag(rd_rsp_data[FLAG_BIT]),
        .seg_valid(seg_valid), .idle_valid(idle_valid),
        .cur_chan(cur_chan), .adv_en(adv_en)
    );

    assign seg_chan  = cur_chan;
    assign seg_addr  = rd_addr;
    assign idle_chan = cur_chan;

    // R2
    addr_align_chk: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (rd_addr[1:0] == 2'b00));
endmodule

// File: tb/txring_poller_bench.sv
module txring_poller_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        svc_valid = 1'b0;
    logic [7:0]  svc_chan = '0;
    logic        svc_ready;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_chan = '0;
    logic [31:0] cfg_base = '0;
    logic        rd_req;
    logic [31:0] rd_addr;
    logic        rd_rsp_valid = 1'b0;
    logic [31:0] rd_rsp_data = '0;
    logic        seg_valid;
    logic [7:0]  seg_chan;
    logic [31:0] seg_addr;
    logic        idle_valid;
    logic [7:0]  idle_chan;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    txring_poller u_txring_poller (
        .clk(clk), .rst(rst),
        .svc_valid(svc_valid), .svc_chan(svc_chan), .svc_ready(svc_ready),
        .cfg_we(cfg_we), .cfg_chan(cfg_chan), .cfg_base(cfg_base),
        .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
        .seg_valid(seg_valid), .seg_chan(seg_chan), .seg_addr(seg_addr),
        .idle_valid(idle_valid), .idle_chan(idle_chan)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_base(input logic [7:0] ch, input logic [31:0] base);
        @(negedge clk);
        cfg_we = 1'b1; cfg_chan = ch; cfg_base = base;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // One scheduler visit; checks the read address and the outcome strobe.
    task automatic visit(input logic [7:0] ch, input bit queued, input int hold,
                         input logic [31:0] exp_addr, input string req);
        @(negedge clk);
        svc_valid = 1'b1; svc_chan = ch;
        @(negedge clk);
        svc_valid = 1'b0;
        check({req, " rd_req"}, 32'(rd_req), 32'd1);
        check({req, " rd_addr"}, rd_addr, exp_addr);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            check("R3 hold rd_req", 32'(rd_req), 32'd1);
            check("R3 hold rd_addr", rd_addr, exp_addr);
        end
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = queued ? 32'h8000_1234 : 32'h7FFF_FFFF;
        @(negedge clk);
        rd_rsp_valid = 1'b0;
        if (queued) begin
            check({req, " R4 seg_valid"}, 32'(seg_valid), 32'd1);
            check({req, " R10 idle_valid"}, 32'(idle_valid), 32'd0);
            check({req, " R4 seg_chan"}, 32'(seg_chan), 32'(ch));
            check({req, " R4 seg_addr"}, seg_addr, exp_addr);
        end else begin
            check({req, " R5 idle_valid"}, 32'(idle_valid), 32'd1);
            check({req, " R10 seg_valid"}, 32'(seg_valid), 32'd0);
            check({req, " R5 idle_chan"}, 32'(idle_chan), 32'(ch));
        end
        @(negedge clk);
        check({req, " back ready"}, 32'(svc_ready), 32'd1);
        check({req, " R10 strobes low"}, 32'({seg_valid, idle_valid}), 32'd0);
    endtask

    task automatic test_reset();
        check("R1 svc_ready", 32'(svc_ready), 32'd1);
        check("R1 rd_req", 32'(rd_req), 32'd0);
        check("R1 strobes", 32'({seg_valid, idle_valid}), 32'd0);
    endtask

    task automatic test_issue_and_stall();
        write_base(8'd5, 32'h1000_0003);
        visit(8'd5, 1'b1, 0, 32'h1000_0000, "R2 first entry");
        visit(8'd5, 1'b1, 2, 32'h1000_0010, "R4 advance");
        visit(8'd5, 1'b0, 1, 32'h1000_0020, "R5 stall");
        visit(8'd5, 1'b0, 0, 32'h1000_0020, "R5 same entry");
        visit(8'd5, 1'b1, 0, 32'h1000_0020, "R5 resume");
        visit(8'd5, 1'b1, 0, 32'h1000_0030, "R5 after resume");
    endtask

    task automatic test_independent();
        write_base(8'd7, 32'h2000_0000);
        visit(8'd7, 1'b1, 0, 32'h2000_0000, "R7 other chan start");
        visit(8'd5, 1'b1, 0, 32'h1000_0040, "R7 chan5 kept");
        visit(8'd7, 1'b1, 0, 32'h2000_0010, "R7 chan7 kept");
    endtask

    task automatic test_chan_zero();
        @(negedge clk);
        svc_valid = 1'b1; svc_chan = 8'd0;
        @(negedge clk);
        svc_valid = 1'b0;
        check("R8 no read", 32'(rd_req), 32'd0);
        check("R8 ready", 32'(svc_ready), 32'd1);
        @(negedge clk);
        check("R8 still no read", 32'(rd_req), 32'd0);
    endtask

    task automatic test_busy_ignore();
        @(negedge clk);
        svc_valid = 1'b1; svc_chan = 8'd7;
        @(negedge clk);
        svc_chan = 8'd5;
        check("R3 busy ready low", 32'(svc_ready), 32'd0);
        check("R3 busy addr", rd_addr, 32'h2000_0020);
        @(negedge clk);
        check("R3 busy addr kept", rd_addr, 32'h2000_0020);
        svc_valid = 1'b0;
        rd_rsp_valid = 1'b1; rd_rsp_data = 32'h8000_0000;
        @(negedge clk);
        rd_rsp_valid = 1'b0;
        check("R3 busy seg chan", 32'(seg_chan), 32'd7);
        @(negedge clk);
        check("R3 no second read", 32'(rd_req), 32'd0);
        visit(8'd5, 1'b1, 0, 32'h1000_0050, "R3 ignored chan untouched");
    endtask

    task automatic test_wrap();
        write_base(8'd9, 32'h3000_0000);
        for (int i = 0; i < 256; i++) begin
            visit(8'd9, 1'b1, 0, 32'h3000_0000 + 32'(i) * 32'd16, "R6 walk");
        end
        visit(8'd9, 1'b0, 0, 32'h3000_0000, "R6 wrapped");
    endtask

    task automatic test_base_clear();
        write_base(8'd5, 32'h1100_0000);
        visit(8'd5, 1'b1, 0, 32'h1100_0000, "R9 write clears");
    endtask

    task automatic test_reset_clears();
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        visit(8'd7, 1'b1, 0, 32'h2000_0000, "R1 index cleared");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        test_reset();
        test_issue_and_stall();
        test_independent();
        test_chan_zero();
        test_busy_ignore();
        test_wrap();
        test_base_clear();
        test_reset_clears();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule